// File: doc/BRIEF.md
# Cascaded 96-Source Interrupt Controller

This block combines 96 interrupt sources into one interrupt line for a CPU. It also produces a vector that names the lowest-numbered source that is both pending and enabled.

The sources are split into three banks of 32:

- **Numbers 0–31** come from the low main cause word. It follows its level inputs directly.
- **Numbers 32–63** come from the high main cause word. It also follows its level inputs.
- **Numbers 64–95** come from a cause word fed by 32 general-purpose port inputs. A bit in this word latches on a rising edge of the synchronised input and stays set until software clears it.

The port bank is cascaded into the high word. Four summary bits in the high word, one for each group of eight port inputs, stand in for the port bank there.

Software uses a one-clock register port. Through it, software enables and disables sources with three mask words, reads the causes, clears latched port causes by writing zeros, and reads the vector. A read returns data on the cycle after the address is presented. A write takes effect at the clock edge that samples it.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Number n in 0–31 is bit n of the low cause, n in 32–63 is bit n-32 of the high cause, n in 64–95 is bit n-64 of the port cause; the vector reports the lowest such number that is pending and enabled.
- R2: The low bank is examined first, then the high bank, then the port bank (reached only through an enabled summary bit), so a low-bank source beats any high or port source.
- R3: Only low cause bits set in 0x3DFFFFFE can be selected or raise the line; bits 0, 25, 30 and 31 never do.
- R4: Only high cause bits set in 0x0F000DB7 can be selected or raise the line.
- R5: High cause bits 24–27 are not taken from the high source inputs; bit 24+g reads as the OR of (port cause AND port mask) over port bits 8g..8g+7.
- R6: After reset the low mask and port mask read 0, the high mask reads 0x0F000000, the port cause reads 0 and the vector reads 0.
- R7: A source is enabled when its mask bit is 1 and disabled when it is 0; this includes the summary bits 24–27 of the high mask.
- R8: A port cause bit sets on a rising edge of its input after a two-stage synchroniser, whatever the port mask, and holds after the input falls.
- R9: Writing the port cause clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R10: A clearing write and a new rising edge on the same port bit at the same clock edge leave that bit set.
- R11: The vector word holds the number in bits 6:0 and a valid flag in bit 7; with nothing qualified it reads 0x00000000.
- R12: The interrupt output is high exactly when a qualified low-bank or high-bank bit (summary bits included) is set.
- R13: Register map (3-bit address): 0 low cause, 1 high cause, 2 low mask, 3 high mask, 4 port cause, 5 port mask, 6 vector; read data appears one clock after the address, and writes to addresses 0, 1 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_src | input | 32 | Level sources for numbers 0–31 |
| hi_src | input | 32 | Level sources for numbers 32–63 (bits 24–27 unused) |
| port_in | input | 32 | Asynchronous port inputs for numbers 64–95 |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Combined interrupt line to the CPU |

## Verification
Two functions can act on the same port cause bit in one clock: a software clearing write and a freshly detected input edge. The bench raises a port input and then times a zero write so that it lands on the exact edge at which the synchronised rise is captured. In the same write it clears a second bit that was already latched. The port cause is then read back: the new bit must be set and the old one clear.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 3;
    localparam int GROUP_W    = 8;
    localparam int NUM_GROUPS = REG_W / GROUP_W;
    localparam int SUM_LSB    = 24;
    localparam int VEC_NUM_W  = 7;
    localparam int BANK_IDX_W = $clog2(REG_W);

    localparam logic [REG_W-1:0] LO_QUAL     = 32'h3DFF_FFFE;
    localparam logic [REG_W-1:0] HI_QUAL     = 32'h0F00_0DB7;
    localparam logic [REG_W-1:0] SUM_FIELD   = {{(REG_W-SUM_LSB-NUM_GROUPS){1'b0}},
                                                {NUM_GROUPS{1'b1}}, {SUM_LSB{1'b0}}};
    localparam logic [REG_W-1:0] HI_MASK_RST = SUM_FIELD;

    typedef enum logic [ADDR_W-1:0] {
        A_LO_CAUSE   = 3'd0,
        A_HI_CAUSE   = 3'd1,
        A_LO_MASK    = 3'd2,
        A_HI_MASK    = 3'd3,
        A_PORT_CAUSE = 3'd4,
        A_PORT_MASK  = 3'd5,
        A_VECTOR     = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic                 valid;
        logic [VEC_NUM_W-1:0] num;
    } vector_t;

endpackage

// File: rtl/irq_port_capture.sv
module irq_port_capture #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_keep,
    output logic [WIDTH-1:0] cause
);

    logic [WIDTH-1:0] sync_q [SYNC_STAGES];
    logic [WIDTH-1:0] last_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= pin;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign keep = clr_en ? clr_keep : '1;

    // a new edge wins over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & keep) | rise;
    end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        found = |vec;
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  lo_src,
    input  logic [REG_W-1:0]  hi_src,
    input  logic [REG_W-1:0]  port_in,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              cpu_irq
);

    logic [REG_W-1:0] lo_mask_q, hi_mask_q, port_mask_q;
    logic [REG_W-1:0] port_cause;
    logic [REG_W-1:0] port_qual, port_sel, grp_en_bits;
    logic [REG_W-1:0] hi_cause, lo_qual, hi_qual, hi_direct;
    logic [NUM_GROUPS-1:0] summary;
    logic lo_found, hi_found, port_found;
    logic [BANK_IDX_W-1:0] lo_idx, hi_idx, port_idx;
    vector_t vec;
    logic vec_valid;
    logic [VEC_NUM_W-1:0] vec_num;
    reg_addr_e addr_e;

    assign addr_e = reg_addr_e'(reg_addr);

    // mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_mask_q   <= '0;
            hi_mask_q   <= HI_MASK_RST;
            port_mask_q <= '0;
        end else if (reg_wen) begin
            if (addr_e == A_LO_MASK)   lo_mask_q   <= reg_wdata;
            if (addr_e == A_HI_MASK)   hi_mask_q   <= reg_wdata;
            if (addr_e == A_PORT_MASK) port_mask_q <= reg_wdata;
        end
    end

    irq_port_capture #(
        .WIDTH      (REG_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (port_in),
        .clr_en  (reg_wen && addr_e == A_PORT_CAUSE),
        .clr_keep(reg_wdata),
        .cause   (port_cause)
    );

    // cascade: one summary bit and one enable per group of port bits
    assign port_qual = port_cause & port_mask_q;
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        assign summary[g] = |port_qual[g*GROUP_W +: GROUP_W];
        assign grp_en_bits[g*GROUP_W +: GROUP_W] = {GROUP_W{hi_mask_q[SUM_LSB+g]}};
    end
    assign port_sel = port_qual & grp_en_bits;

    assign hi_cause  = (hi_src & ~SUM_FIELD)
                     | ({{(REG_W-NUM_GROUPS){1'b0}}, summary} << SUM_LSB);
    assign lo_qual   = lo_src & lo_mask_q & LO_QUAL;
    assign hi_qual   = hi_cause & hi_mask_q & HI_QUAL;
    assign hi_direct = hi_qual & ~SUM_FIELD;

    assign cpu_irq = (|lo_qual) | (|hi_qual);

    irq_lowest_enc #(.WIDTH(REG_W)) u_enc_lo (
        .vec(lo_qual), .found(lo_found), .idx(lo_idx));
    irq_lowest_enc #(.WIDTH(REG_W)) u_enc_hi (
        .vec(hi_direct), .found(hi_found), .idx(hi_idx));
    irq_lowest_enc #(.WIDTH(REG_W)) u_enc_port (
        .vec(port_sel), .found(port_found), .idx(port_idx));

    // low bank first, then high, then the port bank
    always_comb begin
        vec = '0;
        if (lo_found)
            vec = '{valid: 1'b1, num: VEC_NUM_W'(lo_idx)};
        else if (hi_found)
            vec = '{valid: 1'b1, num: VEC_NUM_W'(REG_W) + VEC_NUM_W'(hi_idx)};
        else if (port_found)
            vec = '{valid: 1'b1, num: VEC_NUM_W'(2*REG_W) + VEC_NUM_W'(port_idx)};
    end
    assign vec_valid = vec.valid;
    assign vec_num   = vec.num;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            unique case (addr_e)
                A_LO_CAUSE:   reg_rdata <= lo_src;
                A_HI_CAUSE:   reg_rdata <= hi_cause;
                A_LO_MASK:    reg_rdata <= lo_mask_q;
                A_HI_MASK:    reg_rdata <= hi_mask_q;
                A_PORT_CAUSE: reg_rdata <= port_cause;
                A_PORT_MASK:  reg_rdata <= port_mask_q;
                A_VECTOR:     reg_rdata <= {{(REG_W-VEC_NUM_W-1){1'b0}}, vec};
                default:      reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_cascade_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_W-1:0]     lo_src,
    input logic                 reg_wen,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 cpu_irq,
    input logic                 vec_valid,
    input logic [VEC_NUM_W-1:0] vec_num,
    input logic [REG_W-1:0]     port_cause,
    input logic [REG_W-1:0]     lo_mask_q,
    input logic [REG_W-1:0]     hi_mask_q,
    input logic [REG_W-1:0]     port_mask_q
);

    logic [4:0] bidx;
    assign bidx = vec_num[4:0];

    p_line_matches_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == vec_valid);

    p_low_pick_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num < 7'd32) |->
            (LO_QUAL[bidx] && lo_src[bidx] && lo_mask_q[bidx]));

    p_high_pick_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num >= 7'd32 && vec_num < 7'd64) |->
            (HI_QUAL[bidx] && hi_mask_q[bidx] && (lo_src & lo_mask_q & LO_QUAL) == '0));

    p_port_pick_cascaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num >= 7'd64) |->
            (port_cause[bidx] && port_mask_q[bidx] && hi_mask_q[SUM_LSB + 32'(bidx[4:3])]));

    p_cause_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == A_PORT_CAUSE) |=>
            ((port_cause & $past(port_cause)) == $past(port_cause)));

    p_no_vector_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_num == '0);

    p_reset_state_r6: assert property (@(posedge clk)
        !rst_n |=> (lo_mask_q == '0 && hi_mask_q == HI_MASK_RST
                    && port_mask_q == '0 && port_cause == '0));

endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_src     (lo_src),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .cpu_irq    (cpu_irq),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num),
    .port_cause (port_cause),
    .lo_mask_q  (lo_mask_q),
    .hi_mask_q  (hi_mask_q),
    .port_mask_q(port_mask_q)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lo_src = '0, hi_src = '0, port_in = '0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_cascade_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lo_src(lo_src), .hi_src(hi_src),
        .port_in(port_in), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    localparam logic [2:0] LOC = 3'd0, HIC = 3'd1, LOM = 3'd2, HIM = 3'd3,
                           PC = 3'd4, PM = 3'd5, VEC = 3'd6;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] lom;
        logic [31:0] him;
        logic [7:0]  vec;
        logic        irq;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        '{32'h0000_0004, 32'h0,          32'hFFFF_FFFF, 32'h0F00_0000, 8'h82, 1'b1}, // R1
        '{32'h0000_0001, 32'h0,          32'hFFFF_FFFF, 32'h0F00_0000, 8'h00, 1'b0}, // R3 bit0
        '{32'hC200_0000, 32'h0,          32'hFFFF_FFFF, 32'h0F00_0000, 8'h00, 1'b0}, // R3 25,30,31
        '{32'h0000_0100, 32'h1,          32'h0,         32'h0,         8'h00, 1'b0}, // R7 masked
        '{32'h0001_0010, 32'h1,          32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h84, 1'b1}, // R2 R1
        '{32'h0,         32'h0000_0088,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hA7, 1'b1}, // R4 39
        '{32'h0,         32'h0000_0008,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, 1'b0}, // R4 bit3
        '{32'h0,         32'hF000_0040,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, 1'b0}, // R4 invalid
        '{32'h0,         32'h0000_0C00,  32'hFFFF_FFFF, 32'h0000_0800, 8'hAB, 1'b1}, // R7 43
        '{32'h0100_0000, 32'h0F00_0001,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h98, 1'b1}  // R5 R2 24
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic pulse_port(input int bitn);
        @(negedge clk);
        port_in[bitn] = 1'b1;
        repeat (3) @(negedge clk);
        port_in[bitn] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        rd(LOM, d); check("R6 low mask", d, 32'h0);
        rd(HIM, d); check("R6 high mask", d, 32'h0F00_0000);
        rd(PM, d);  check("R6 port mask", d, 32'h0);
        rd(PC, d);  check("R6 port cause", d, 32'h0);
        rd(VEC, d); check("R6 R11 vector", d, 32'h0);

        // table of level-source patterns
        for (int i = 0; i < NROWS; i++) begin
            wr(LOM, TBL[i].lom);
            wr(HIM, TBL[i].him);
            @(negedge clk);
            lo_src = TBL[i].lo;
            hi_src = TBL[i].hi;
            rd(VEC, d);
            check($sformatf("R1 R2 R3 R4 R11 row %0d vector", i), d, {24'h0, TBL[i].vec});
            check($sformatf("R12 row %0d line", i), {31'h0, cpu_irq}, {31'h0, TBL[i].irq});
        end
        @(negedge clk);
        lo_src = '0; hi_src = '0;
        wr(LOM, 32'h0);
        wr(HIM, 32'h0F00_0000);

        // R8 port edge capture through cascade
        wr(PM, 32'h0000_1020);
        pulse_port(5);
        rd(PC, d);  check("R8 port cause set", d, 32'h0000_0020);
        rd(HIC, d); check("R5 summary bit 24", d, 32'h0100_0000);
        rd(VEC, d); check("R1 R5 vector 69", d, 32'h0000_00C5);
        check("R12 line from summary", {31'h0, cpu_irq}, 32'h1);
        pulse_port(12);
        rd(PC, d);  check("R8 cause holds after fall", d, 32'h0000_1020);
        rd(VEC, d); check("R1 lowest port wins", d, 32'h0000_00C5);

        // R7 summary mask removes group 0
        wr(HIM, 32'h0E00_0000);
        rd(VEC, d); check("R7 group 0 disabled", d, 32'h0000_00CC);
        rd(HIC, d); check("R5 summary independent of high mask", d, 32'h0300_0000);
        wr(HIM, 32'h0F00_0000);

        // R2 bank priority
        @(negedge clk); lo_src = 32'h2;
        wr(LOM, 32'h2);
        rd(VEC, d); check("R2 low beats port", d, 32'h0000_0081);
        @(negedge clk); lo_src = '0; hi_src = 32'h1;
        wr(HIM, 32'h0F00_0001);
        rd(VEC, d); check("R2 high beats port", d, 32'h0000_00A0);
        @(negedge clk); hi_src = '0;
        wr(HIM, 32'h0F00_0000);

        // R9 write-zero clear
        wr(PC, 32'hFFFF_EFFF);
        rd(PC, d);  check("R9 zero clears, ones keep", d, 32'h0000_0020);
        wr(PC, 32'h0);
        rd(PC, d);  check("R9 clear all", d, 32'h0);
        rd(VEC, d); check("R11 no interrupt code", d, 32'h0);
        check("R12 line low", {31'h0, cpu_irq}, 32'h0);

        // R10 clearing write on the capture edge
        pulse_port(5);
        @(negedge clk); port_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = PC; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wen = 1'b0; port_in[3] = 1'b0;
        rd(PC, d);  check("R10 edge survives clear", d, 32'h0000_0008);
        // R8 masked port bit latches but stays silent
        rd(VEC, d); check("R8 masked port bit no vector", d, 32'h0);

        // R13 writes to read-only addresses change nothing
        wr(LOC, 32'hFFFF_FFFF);
        wr(VEC, 32'hFFFF_FFFF);
        rd(LOC, d); check("R13 low cause read-only", d, 32'h0);
        rd(LOM, d); check("R13 low mask untouched", d, 32'h0000_0002);
        rd(VEC, d); check("R13 vector read-only", d, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule